// File: doc/BRIEF.md
# Load-Balancing Frame Allocation Arbiter

This block is the central scheduler of one node of cores. It keeps a live count of how many thread frames each core currently holds. When a frame-allocation request arrives, a combinational picker reads the count table and chooses the least-loaded core that still has room. The block forwards the request to that core and then returns an allocation response naming the chosen core to the requester. Frame-free messages lower the count of the core that owned the frame, so new work keeps spreading across the node.

A three-state sequencer runs each allocation. In IDLE it offers `alloc_ready` while some core has room. An accepted request (transition IDLE->ISSUE) raises the chosen core's count. In ISSUE it presents the forward until the core takes it (ISSUE->REPLY). In REPLY it presents the response until the requester takes it (REPLY->IDLE). Any other state value returns to IDLE.

The per-core counts can be read through a memory-mapped window on a shared bus. An address router checks each bus transaction against the window. Transactions inside the window go to the count registers. All other transactions are sent unchanged to a pass-through port, and that port's read data is returned.

Top module: `fa_balancer`

## Requirements
- R1: After reset every count reads 0, the sequencer is in IDLE with `alloc_ready` high, and `fwd_valid` and `rsp_valid` are low.
- R2: The forwarded core is the core with the smallest count among the cores below CNT_MAX. When several cores share that count, the lowest index wins.
- R3: An accepted request (`alloc_valid` and `alloc_ready` high at a clock edge) raises the chosen core's count by one at that edge. `fwd_valid` is high in the next cycle.
- R4: After acceptance, `fwd_valid` stays high with `fwd_core` and `fwd_src` held until a cycle with `fwd_ready` high. Then `rsp_valid` stays high, with the same core in `rsp_core` and the requester id in `rsp_src`, until a cycle with `rsp_ready` high. `alloc_ready` is low outside IDLE.
- R5: A free message (`free_valid` with `free_core`) lowers that core's count by one. A free to a core whose count is 0 is ignored.
- R6: An accepted request and a free that name the same core in one cycle leave a nonzero count unchanged.
- R7: A core whose count equals CNT_MAX (15 by default) is never chosen. When every core is at CNT_MAX, `alloc_ready` is low and no request is accepted.
- R8: A bus address in [WIN_BASE, WIN_BASE+2^WIN_BITS) (0x4000..0x403F by default) hits the window. In that case `pt_valid` stays low. A read of byte offset 4*i returns the count of core i, zero-extended, for i < NCORE. Any other offset in the window reads 0.
- R9: A bus transaction outside the window drives `pt_valid` high, with `pt_we`, `pt_addr` and `pt_wdata` equal to the bus values, and `bus_rdata` equals `pt_rdata`.
- R10: Bus writes inside the window have no effect on any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Frame-allocation request present |
| alloc_src | input | SRCW | Requester id |
| alloc_ready | output | 1 | Request accepted this cycle if valid |
| fwd_valid | output | 1 | Forwarded request to a core |
| fwd_core | output | CW | Chosen core |
| fwd_src | output | SRCW | Requester id carried with the forward |
| fwd_ready | input | 1 | Core takes the forward |
| rsp_valid | output | 1 | Allocation response to requester |
| rsp_core | output | CW | Core holding the new frame |
| rsp_src | output | SRCW | Requester the response is for |
| rsp_ready | input | 1 | Requester takes the response |
| free_valid | input | 1 | Frame-free message |
| free_core | input | CW | Core that owned the freed frame |
| bus_valid | input | 1 | Bus transaction present |
| bus_we | input | 1 | Bus write |
| bus_addr | input | AW | Bus byte address |
| bus_wdata | input | DW | Bus write data |
| bus_rdata | output | DW | Bus read data |
| pt_valid | output | 1 | Pass-through transaction present |
| pt_we | output | 1 | Pass-through write |
| pt_addr | output | AW | Pass-through address |
| pt_wdata | output | DW | Pass-through write data |
| pt_rdata | input | DW | Pass-through read data |

## Verification
The assertions assume that the window base is aligned to the window size. They also assume that `free_core` is below NCORE and that a core is never freed more often than it was given frames. The random stimulus draws `free_core` only from valid core indices, and the count model in the bench keeps the zero case legal. The handshake checks assume that `fwd_ready` and `rsp_ready` may arrive in any cycle. The bench therefore randomises them independently, so forwards and responses are held for random spans. Bus addresses are drawn both inside the default window and from a separate region above it.

// File: rtl/fa_pkg.sv
package fa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_REPLY = 2'd2
    } fa_state_e;
endpackage

// File: rtl/fa_occupancy.sv
module fa_occupancy #(
    parameter int NCORE   = 8,
    parameter int CNT_MAX = 15,
    localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1,
    localparam int KW = $clog2(CNT_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc_en,
    input  logic [CW-1:0]       inc_core,
    input  logic                dec_en,
    input  logic [CW-1:0]       dec_core,
    output logic [NCORE*KW-1:0] cnt_flat
);
    for (genvar i = 0; i < NCORE; i++) begin : g_core
        logic [KW-1:0] cnt_q;
        logic          up, down;

        assign up   = inc_en && (inc_core == CW'(i)) && (cnt_q != KW'(CNT_MAX));
        assign down = dec_en && (dec_core == CW'(i)) && (cnt_q != '0);

        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (up && !down)
                cnt_q <= cnt_q + 1'b1;
            else if (down && !up)
                cnt_q <= cnt_q - 1'b1;
        end

        assign cnt_flat[i*KW +: KW] = cnt_q;
    end
endmodule

// File: rtl/fa_pick.sv
module fa_pick #(
    parameter int NCORE   = 8,
    parameter int CNT_MAX = 15,
    localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1,
    localparam int KW = $clog2(CNT_MAX + 1)
) (
    input  logic [NCORE*KW-1:0] cnt_flat,
    output logic                any_room,
    output logic [CW-1:0]       pick_core
);
    logic [KW-1:0] best_cnt;
    logic [KW-1:0] cur;

    always_comb begin
        any_room  = 1'b0;
        pick_core = '0;
        best_cnt  = '0;
        cur       = '0;
        for (int i = 0; i < NCORE; i++) begin
            cur = cnt_flat[i*KW +: KW];
            if (cur != KW'(CNT_MAX) && (!any_room || cur < best_cnt)) begin
                any_room  = 1'b1;
                pick_core = CW'(i);
                best_cnt  = cur;
            end
        end
    end
endmodule

// File: rtl/fa_router.sv
module fa_router #(
    parameter int            NCORE    = 8,
    parameter int            CNT_MAX  = 15,
    parameter int            AW       = 16,
    parameter int            DW       = 32,
    parameter int            WIN_BITS = 6,
    parameter logic [AW-1:0] WIN_BASE = 16'h4000,
    localparam int KW = $clog2(CNT_MAX + 1),
    localparam int IW = WIN_BITS - 2
) (
    input  logic                bus_valid,
    input  logic                bus_we,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [NCORE*KW-1:0] cnt_flat,
    output logic                pt_valid,
    output logic                pt_we,
    output logic [AW-1:0]       pt_addr,
    output logic [DW-1:0]       pt_wdata,
    input  logic [DW-1:0]       pt_rdata
);
    logic          hit;
    logic [IW-1:0] word;
    logic [DW-1:0] reg_rdata;

    assign hit  = (bus_addr[AW-1:WIN_BITS] == WIN_BASE[AW-1:WIN_BITS]);
    assign word = bus_addr[WIN_BITS-1:2];

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NCORE; i++)
            if (word == IW'(i))
                reg_rdata = DW'(cnt_flat[i*KW +: KW]);
    end

    assign pt_valid  = bus_valid && !hit;
    assign pt_we     = bus_we;
    assign pt_addr   = bus_addr;
    assign pt_wdata  = bus_wdata;
    assign bus_rdata = hit ? reg_rdata : pt_rdata;
endmodule

// File: rtl/fa_balancer.sv
module fa_balancer #(
    parameter int            NCORE    = 8,
    parameter int            CNT_MAX  = 15,
    parameter int            SRCW     = 4,
    parameter int            AW       = 16,
    parameter int            DW       = 32,
    parameter int            WIN_BITS = 6,
    parameter logic [AW-1:0] WIN_BASE = 16'h4000,
    localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1,
    localparam int KW = $clog2(CNT_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_valid,
    input  logic [SRCW-1:0] alloc_src,
    output logic            alloc_ready,
    output logic            fwd_valid,
    output logic [CW-1:0]   fwd_core,
    output logic [SRCW-1:0] fwd_src,
    input  logic            fwd_ready,
    output logic            rsp_valid,
    output logic [CW-1:0]   rsp_core,
    output logic [SRCW-1:0] rsp_src,
    input  logic            rsp_ready,
    input  logic            free_valid,
    input  logic [CW-1:0]   free_core,
    input  logic            bus_valid,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            pt_valid,
    output logic            pt_we,
    output logic [AW-1:0]   pt_addr,
    output logic [DW-1:0]   pt_wdata,
    input  logic [DW-1:0]   pt_rdata
);
    import fa_pkg::*;

    fa_state_e           state_q, state_d;
    logic [CW-1:0]       core_q;
    logic [SRCW-1:0]     src_q;
    logic [NCORE*KW-1:0] cnt_flat;
    logic                any_room;
    logic [CW-1:0]       pick_core;
    logic                accept;

    assign accept = (state_q == ST_IDLE) && alloc_valid && any_room;

    fa_occupancy #(.NCORE(NCORE), .CNT_MAX(CNT_MAX)) u_occ (
        .clk(clk), .rst_n(rst_n),
        .inc_en(accept), .inc_core(pick_core),
        .dec_en(free_valid), .dec_core(free_core),
        .cnt_flat(cnt_flat)
    );

    fa_pick #(.NCORE(NCORE), .CNT_MAX(CNT_MAX)) u_pick (
        .cnt_flat(cnt_flat), .any_room(any_room), .pick_core(pick_core)
    );

    fa_router #(
        .NCORE(NCORE), .CNT_MAX(CNT_MAX), .AW(AW), .DW(DW),
        .WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE)
    ) u_rtr (
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_flat(cnt_flat),
        .pt_valid(pt_valid), .pt_we(pt_we), .pt_addr(pt_addr),
        .pt_wdata(pt_wdata), .pt_rdata(pt_rdata)
    );

    // state register and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            core_q  <= '0;
            src_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                core_q <= pick_core;
                src_q  <= alloc_src;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)    state_d = ST_ISSUE;
            ST_ISSUE: if (fwd_ready) state_d = ST_REPLY;
            ST_REPLY: if (rsp_ready) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        alloc_ready = 1'b0;
        fwd_valid   = 1'b0;
        rsp_valid   = 1'b0;
        unique case (state_q)
            ST_IDLE:  alloc_ready = any_room;
            ST_ISSUE: fwd_valid   = 1'b1;
            ST_REPLY: rsp_valid   = 1'b1;
            default:  ;
        endcase
        fwd_core = core_q;
        fwd_src  = src_q;
        rsp_core = core_q;
        rsp_src  = src_q;
    end
endmodule

// File: rtl/fa_balancer_chk.sv
module fa_balancer_chk #(
    parameter int            CW       = 3,
    parameter int            SRCW     = 4,
    parameter int            AW       = 16,
    parameter int            WIN_BITS = 6,
    parameter logic [AW-1:0] WIN_BASE = 16'h4000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            alloc_valid,
    input logic            alloc_ready,
    input logic            fwd_valid,
    input logic [CW-1:0]   fwd_core,
    input logic [SRCW-1:0] fwd_src,
    input logic            fwd_ready,
    input logic            rsp_valid,
    input logic [CW-1:0]   rsp_core,
    input logic            bus_valid,
    input logic [AW-1:0]   bus_addr,
    input logic            pt_valid
);
    localparam logic [AW:0] WIN_END = {1'b0, WIN_BASE} + (AW+1)'(1 << WIN_BITS);
    logic in_win;
    assign in_win = ({1'b0, bus_addr} >= {1'b0, WIN_BASE}) && ({1'b0, bus_addr} < WIN_END);

    // R3
    accept_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid && alloc_ready |=> fwd_valid);

    // R4
    fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_core) && $stable(fwd_src));

    // R4
    fwd_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid && fwd_ready |=> rsp_valid && !fwd_valid && rsp_core == $past(fwd_core));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ready |-> !fwd_valid && !rsp_valid);

    // R8
    win_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && in_win |-> !pt_valid);

    // R9
    outside_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !in_win |-> pt_valid);
endmodule

bind fa_balancer fa_balancer_chk #(
    .CW(CW), .SRCW(SRCW), .AW(AW), .WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .fwd_valid(fwd_valid), .fwd_core(fwd_core), .fwd_src(fwd_src), .fwd_ready(fwd_ready),
    .rsp_valid(rsp_valid), .rsp_core(rsp_core), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .pt_valid(pt_valid)
);

// File: tb/sim_fa_balancer.sv
`timescale 1ns/100ps
module sim_fa_balancer;
    localparam int NC = 8;
    localparam int MAXC = 15;
    localparam int BASE = 'h4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 0, fwd_ready = 0, rsp_ready = 0, free_valid = 0;
    logic [3:0]  alloc_src = '0;
    logic [2:0]  free_core = '0;
    logic        bus_valid = 0, bus_we = 0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, pt_rdata = '0;
    logic        alloc_ready, fwd_valid, rsp_valid, pt_valid, pt_we;
    logic [2:0]  fwd_core, rsp_core;
    logic [3:0]  fwd_src, rsp_src;
    logic [15:0] pt_addr;
    logic [31:0] pt_wdata, bus_rdata;

    always #2.5 clk = ~clk;

    fa_balancer u0 (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_src(alloc_src),
        .alloc_ready(alloc_ready), .fwd_valid(fwd_valid), .fwd_core(fwd_core),
        .fwd_src(fwd_src), .fwd_ready(fwd_ready), .rsp_valid(rsp_valid),
        .rsp_core(rsp_core), .rsp_src(rsp_src), .rsp_ready(rsp_ready),
        .free_valid(free_valid), .free_core(free_core), .bus_valid(bus_valid),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pt_valid(pt_valid), .pt_we(pt_we),
        .pt_addr(pt_addr), .pt_wdata(pt_wdata), .pt_rdata(pt_rdata)
    );

    int errs = 0, nchk = 0;
    int mcnt[NC];
    int mst = 0, mcore = 0, msrc = 0;
    int last_rdata = 0, last_fwd = -1;
    bit done = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int pickf();
        int b = -1;
        for (int i = 0; i < NC; i++)
            if (mcnt[i] < MAXC && (b < 0 || mcnt[i] < mcnt[b])) b = i;
        return b;
    endfunction

    function automatic bit in_win(int a);
        return a >= BASE && a < BASE + 64;
    endfunction

    // one clock: sample outputs, update model, advance
    task automatic cyc();
        int p;
        bit room, dec;
        #1;
        p = pickf();
        room = (p >= 0);
        chk(alloc_ready == ((mst == 0) && room), "R4", "alloc_ready", alloc_ready, (mst == 0) && room);
        if (mst == 0 && !room) chk(alloc_ready == 0, "R7", "ready when all full", alloc_ready, 0);
        chk(fwd_valid == (mst == 1), "R4", "fwd_valid", fwd_valid, mst == 1);
        chk(rsp_valid == (mst == 2), "R4", "rsp_valid", rsp_valid, mst == 2);
        if (mst == 1) begin
            chk(int'(fwd_core) == mcore, "R2", "fwd_core", fwd_core, mcore);
            chk(int'(fwd_src) == msrc, "R4", "fwd_src", fwd_src, msrc);
            last_fwd = fwd_core;
        end
        if (mst == 2) begin
            chk(int'(rsp_core) == mcore, "R4", "rsp_core", rsp_core, mcore);
            chk(int'(rsp_src) == msrc, "R4", "rsp_src", rsp_src, msrc);
        end
        if (!bus_valid) chk(pt_valid == 0, "R9", "pt_valid idle", pt_valid, 0);
        else if (in_win(bus_addr)) begin
            chk(pt_valid == 0, "R8", "pt_valid in window", pt_valid, 0);
            if (!bus_we) begin
                int w = bus_addr[5:2];
                int e = (w < NC) ? mcnt[w] : 0;
                chk(bus_rdata == 32'(e), "R8", "register read", bus_rdata, e);
                last_rdata = bus_rdata;
            end
        end else begin
            chk(pt_valid == 1, "R9", "pt_valid", pt_valid, 1);
            chk(pt_addr == bus_addr && pt_we == bus_we && pt_wdata == bus_wdata,
                "R9", "pt fields", pt_addr, bus_addr);
            chk(bus_rdata == pt_rdata, "R9", "pt read data", bus_rdata, pt_rdata);
        end
        dec = free_valid && mcnt[free_core] > 0;
        if (dec) mcnt[free_core]--;
        if (mst == 0 && alloc_valid && room) begin
            mcnt[p]++; mcore = p; msrc = alloc_src; mst = 1;
        end else if (mst == 1 && fwd_ready) mst = 2;
        else if (mst == 2 && rsp_ready) mst = 0;
        @(posedge clk);
        #0.2;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #0.2;
        rst_n = 1;
        foreach (mcnt[i]) mcnt[i] = 0;
        mst = 0;
    endtask

    task automatic read_cnt(int core, int exp, string req);
        bus_valid = 1; bus_we = 0; bus_addr = 16'(BASE + 4 * core);
        cyc();
        bus_valid = 0;
        chk(last_rdata == exp, req, $sformatf("count of core %0d", core), last_rdata, exp);
    endtask

    task automatic alloc_one(int src);
        alloc_valid = 1; alloc_src = 4'(src);
        cyc();
        alloc_valid = 0; fwd_ready = 1;
        cyc();
        fwd_ready = 0; rsp_ready = 1;
        cyc();
        rsp_ready = 0;
    endtask

    task automatic free_one(int core);
        free_valid = 1; free_core = 3'(core);
        cyc();
        free_valid = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            nchk++; errs++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, nchk);
            $finish;
        end
    end

    initial begin
        int r;
        r = $urandom(32'h5eed);
        do_reset();
        // R1 reset state
        #1;
        chk(alloc_ready == 1 && fwd_valid == 0 && rsp_valid == 0, "R1", "reset outputs", alloc_ready, 1);
        for (int i = 0; i < NC; i++) read_cnt(i, 0, "R1");

        // R2 ties go to lowest index
        for (int i = 0; i < NC; i++) begin
            alloc_one(i);
            chk(last_fwd == i, "R2", "tie order", last_fwd, i);
        end
        read_cnt(4, 1, "R3");
        free_one(3);
        read_cnt(3, 0, "R5");
        alloc_one(9);
        chk(last_fwd == 3, "R2", "least loaded", last_fwd, 3);
        read_cnt(3, 1, "R3");
        // R5 free at zero ignored
        free_one(5);
        free_one(5);
        read_cnt(5, 0, "R5");
        alloc_one(2);
        chk(last_fwd == 5, "R2", "refill", last_fwd, 5);
        // R6 accept and free same core
        alloc_valid = 1; free_valid = 1; free_core = 3'd0;
        cyc();
        alloc_valid = 0; free_valid = 0; fwd_ready = 1;
        cyc();
        fwd_ready = 0; rsp_ready = 1;
        cyc();
        rsp_ready = 0;
        chk(last_fwd == 0, "R6", "core picked", last_fwd, 0);
        read_cnt(0, 1, "R6");
        // R10 window write ignored
        bus_valid = 1; bus_we = 1; bus_addr = 16'(BASE + 8); bus_wdata = 32'd9;
        cyc();
        bus_we = 0; bus_valid = 0;
        read_cnt(2, 1, "R10");
        // R8 unused window word
        read_cnt(12, 0, "R8");
        // R9 pass-through
        bus_valid = 1; bus_we = 1; bus_addr = 16'h1234; bus_wdata = 32'hCAFE0001; pt_rdata = 32'h0BADF00D;
        cyc();
        bus_we = 0; bus_addr = 16'h4040;
        cyc();
        bus_valid = 0;
        // R7 fill every core
        for (int k = 0; k < NC * (MAXC - 1); k++) alloc_one(k);
        for (int i = 0; i < NC; i++) read_cnt(i, MAXC, "R7");
        alloc_valid = 1;
        #1;
        chk(alloc_ready == 0, "R7", "full backpressure", alloc_ready, 0);
        cyc();
        cyc();
        chk(fwd_valid == 0, "R7", "no forward when full", fwd_valid, 0);
        alloc_valid = 0;
        free_one(6);
        alloc_one(1);
        chk(last_fwd == 6, "R7", "only non-full core", last_fwd, 6);

        // random phase
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            alloc_valid = ($urandom % 3) != 0;
            alloc_src   = 4'($urandom);
            fwd_ready   = ($urandom % 2) != 0;
            rsp_ready   = ($urandom % 2) != 0;
            free_valid  = ($urandom % 3) == 0;
            free_core   = 3'($urandom % NC);
            bus_valid   = ($urandom % 2) != 0;
            bus_we      = ($urandom % 4) == 0;
            bus_addr    = (($urandom % 2) != 0) ? 16'(BASE + ($urandom % 64)) : 16'(16'h8000 + ($urandom % 512));
            bus_wdata   = $urandom;
            pt_rdata    = $urandom;
            cyc();
        end
        alloc_valid = 0; free_valid = 0; bus_valid = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end
endmodule